// File: doc/BRIEF.md
# SIMT Warp Divergence Mask Unit

This block steers the single instruction stream of one warp, by default 32 lanes, through conditional branches. Every lane shares one fetched instruction per issue. The unit keeps the warp's program counter and its active-lane mask. When a branch arrives, it checks whether the participating lanes agree. If they agree, it follows the chosen path with no added cycles. If they disagree, it runs the taken group first with the other lanes switched off. It then runs the fall-through group, and it restores the original lane set once both groups reach the reconvergence address supplied with the branch.

Fetch, decode and the lane datapaths sit outside the block. They read `pc_o` to fetch, and they use `lane_en_o` as the per-lane write enable, so a lane that is switched off never updates architectural state.

Each divergence pushes a record onto a bounded stack. A record holds the reconvergence address, the address and lane set of the path still owed, and the lane set to restore. The stack unwinds last-in first-out, so nested and chained two-way splits serialize once per distinct path. A warp launch loads the start address and the number of live threads. Lanes above that count stay off for the whole warp.

Top module: `simt_mask_unit`

## Requirements
- R1: After reset, `pc_o` equals RESET_PC (0) and `mask_o` is all ones. `overflow_o` and `hold_o` are 0 and the stack is empty.
- R2: A cycle with `launch_i` high has priority over every other input. On the next cycle `pc_o` equals `launch_pc_i`, and `mask_o` has bit i set exactly when i < `launch_cnt_i`. The stack is empty again and `overflow_o` is 0.
- R3: An accepted issue with `br_i` low advances `pc_o` by PC_STEP (4) and leaves `mask_o` unchanged.
- R4: For an accepted branch, the effective vector is `br_taken_i` AND `mask_o`. If that vector is zero, `pc_o` becomes `br_fall_i`. If it equals `mask_o`, `pc_o` becomes `br_target_i`. In both cases the mask is unchanged, nothing is pushed, and no hold cycle occurs later at `br_reconv_i`.
- R5: When the effective vector is neither zero nor the full mask, the branch is a split. On the next cycle `pc_o` equals `br_target_i` and `mask_o` equals the effective vector.
- R6: `hold_o` is high while the stack is non-empty and `pc_o` equals the top record's reconvergence address. If the top record still owes a path, the held cycle ignores `issue_i`. The next cycle then shows the pending fall-through address and the lanes that did not take the branch.
- R7: A held cycle whose top record owes no path pops the record. `pc_o` stays at the reconvergence address and `mask_o` returns to the lane set that was active before the split.
- R8: Nested splits unwind last-in first-out. The inner split finishes both of its paths and restores its own lane set before the outer split's pending path runs.
- R9: A split that arrives while DEPTH (4) records are stored sets `overflow_o`. Nothing is pushed, `pc_o` goes to `br_target_i`, and `mask_o` is unchanged. `overflow_o` stays high until the next launch or reset.
- R10: `lane_en_o` equals `mask_o` in a cycle where `issue_i` is high and both `hold_o` and `launch_i` are low. In every other cycle it is zero.
- R11: Lanes at or above the launched thread count never appear in `mask_o` or `lane_en_o`, whatever `br_taken_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Start a new warp |
| launch_pc_i | input | PC_W | Start address of the new warp |
| launch_cnt_i | input | $clog2(LANES+1) | Number of live threads in the new warp |
| issue_i | input | 1 | An instruction at `pc_o` is issued this cycle |
| br_i | input | 1 | The issued instruction is a conditional branch |
| br_taken_i | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target_i | input | PC_W | Taken-path address |
| br_fall_i | input | PC_W | Fall-through address |
| br_reconv_i | input | PC_W | Address where both paths rejoin |
| pc_o | output | PC_W | Address of the shared instruction stream |
| mask_o | output | LANES | Active-lane mask |
| lane_en_o | output | LANES | Per-lane architectural write enable for this issue |
| hold_o | output | 1 | Reconvergence bookkeeping cycle; the issue is not accepted |
| overflow_o | output | 1 | Sticky flag: a split exceeded the stack depth |

## Verification
The hardest state to reach from the ports is a fully occupied stack that then receives a further split. Each of the four nested splits must divide the lanes that survived the previous one, and no reconvergence address may be met on the way. A directed sequence narrows the taken vector at each level, from 16 lanes down to 1, and places every reconvergence address far ahead. Constrained random branches with nearby reconvergence addresses then drive the warp through nesting and unwinding. Every cycle of that run is compared with a bench model of the stack.

// File: rtl/simt_pkg.sv
package simt_pkg;
   // Outcome of one branch evaluated against the active lanes
   typedef enum logic [1:0] {
      BR_NONE     = 2'd0,
      BR_UNI_FALL = 2'd1,
      BR_UNI_TAKE = 2'd2,
      BR_SPLIT    = 2'd3
   } br_kind_e;
endpackage

// File: rtl/simt_lane_thermo.sv
// Converts a live-thread count into a low-aligned lane mask.
module simt_lane_thermo #(
   parameter int LANES = 32,
   parameter int CW    = $clog2(LANES + 1)
) (
   input  logic [CW-1:0]    cnt_i,
   output logic [LANES-1:0] mask_o
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask_o[i] = (32'(cnt_i) > i);
   end
endmodule

// File: rtl/simt_br_classify.sv
// Classifies a branch against the active lanes.
module simt_br_classify
   import simt_pkg::*;
#(
   parameter int LANES = 32
) (
   input  logic             valid_i,
   input  logic [LANES-1:0] taken_i,
   input  logic [LANES-1:0] mask_i,
   output logic [LANES-1:0] eff_o,
   output br_kind_e         kind_o
);
   always_comb begin
      eff_o = taken_i & mask_i;
      if (!valid_i)
         kind_o = BR_NONE;
      else if (eff_o == '0)
         kind_o = BR_UNI_FALL;
      else if (eff_o == mask_i)
         kind_o = BR_UNI_TAKE;
      else
         kind_o = BR_SPLIT;
   end
endmodule

// File: rtl/simt_recon_stack.sv
// Bounded LIFO of reconvergence records.
module simt_recon_stack #(
   parameter int PC_W  = 32,
   parameter int LANES = 32,
   parameter int DEPTH = 4,
   localparam int SPW  = $clog2(DEPTH + 1),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic [PC_W-1:0]  push_rpc_i,
   input  logic [PC_W-1:0]  push_ppc_i,
   input  logic [LANES-1:0] push_pm_i,
   input  logic [LANES-1:0] push_sm_i,
   input  logic             clr_pend_i,
   input  logic             pop_i,
   output logic             empty_o,
   output logic             full_o,
   output logic [SPW-1:0]   depth_o,
   output logic [PC_W-1:0]  top_rpc_o,
   output logic [PC_W-1:0]  top_ppc_o,
   output logic [LANES-1:0] top_pm_o,
   output logic [LANES-1:0] top_sm_o
);
   logic [PC_W-1:0]  rpc_q [DEPTH];
   logic [PC_W-1:0]  ppc_q [DEPTH];
   logic [LANES-1:0] pm_q  [DEPTH];
   logic [LANES-1:0] sm_q  [DEPTH];
   logic [SPW-1:0]   sp_q;
   logic [AW-1:0]    wr_idx, top_idx;

   assign wr_idx  = AW'(sp_q);
   assign top_idx = AW'(sp_q - 1'b1);
   assign empty_o = (sp_q == '0);
   assign full_o  = (sp_q == SPW'(DEPTH));
   assign depth_o = sp_q;

   assign top_rpc_o = rpc_q[top_idx];
   assign top_ppc_o = ppc_q[top_idx];
   assign top_pm_o  = pm_q[top_idx];
   assign top_sm_o  = sm_q[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= '0;
      else if (flush_i)
         sp_q <= '0;
      else if (push_i && !full_o)
         sp_q <= sp_q + 1'b1;
      else if (pop_i && !empty_o)
         sp_q <= sp_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!flush_i && push_i && !full_o) begin
         rpc_q[wr_idx] <= push_rpc_i;
         ppc_q[wr_idx] <= push_ppc_i;
         pm_q[wr_idx]  <= push_pm_i;
         sm_q[wr_idx]  <= push_sm_i;
      end else if (!flush_i && clr_pend_i && !empty_o) begin
         pm_q[top_idx] <= '0;
      end
   end

   // R9: the controller never pushes into a full stack
   p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R7: a pop always has a record to remove
   p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
   // R2: a flush leaves the stack empty
   p_flush_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o);
endmodule

// File: rtl/simt_mask_unit.sv
// Warp program counter and active-lane mask with divergence stack.
module simt_mask_unit
   import simt_pkg::*;
#(
   parameter int          LANES    = 32,
   parameter int          PC_W     = 32,
   parameter int          DEPTH    = 4,
   parameter int          PC_STEP  = 4,
   parameter logic [31:0] RESET_PC = 32'h0,
   localparam int         CW       = $clog2(LANES + 1),
   localparam int         SPW      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic [PC_W-1:0]  launch_pc_i,
   input  logic [CW-1:0]    launch_cnt_i,
   input  logic             issue_i,
   input  logic             br_i,
   input  logic [LANES-1:0] br_taken_i,
   input  logic [PC_W-1:0]  br_target_i,
   input  logic [PC_W-1:0]  br_fall_i,
   input  logic [PC_W-1:0]  br_reconv_i,
   output logic [PC_W-1:0]  pc_o,
   output logic [LANES-1:0] mask_o,
   output logic [LANES-1:0] lane_en_o,
   output logic             hold_o,
   output logic             overflow_o
);
   if (LANES < 2) begin : g_bad_lanes
      $error("simt_mask_unit: LANES must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("simt_mask_unit: DEPTH must be at least 1");
   end
   if (PC_STEP < 1) begin : g_bad_step
      $error("simt_mask_unit: PC_STEP must be positive");
   end

   logic [PC_W-1:0]  pc_q;
   logic [LANES-1:0] mask_q, valid_q, eff, launch_mask;
   logic             ovf_q;
   br_kind_e         kind;

   logic             st_empty, st_full, st_push, st_pop, st_clr;
   logic [SPW-1:0]   st_depth;
   logic [PC_W-1:0]  top_rpc, top_ppc;
   logic [LANES-1:0] top_pm, top_sm;

   logic hold, accept;

   simt_lane_thermo #(.LANES(LANES), .CW(CW)) u_thermo (
      .cnt_i  (launch_cnt_i),
      .mask_o (launch_mask)
   );

   simt_br_classify #(.LANES(LANES)) u_cls (
      .valid_i (accept && br_i),
      .taken_i (br_taken_i),
      .mask_i  (mask_q),
      .eff_o   (eff),
      .kind_o  (kind)
   );

   simt_recon_stack #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (launch_i),
      .push_i     (st_push),
      .push_rpc_i (br_reconv_i),
      .push_ppc_i (br_fall_i),
      .push_pm_i  (mask_q & ~br_taken_i),
      .push_sm_i  (mask_q),
      .clr_pend_i (st_clr),
      .pop_i      (st_pop),
      .empty_o    (st_empty),
      .full_o     (st_full),
      .depth_o    (st_depth),
      .top_rpc_o  (top_rpc),
      .top_ppc_o  (top_ppc),
      .top_pm_o   (top_pm),
      .top_sm_o   (top_sm)
   );

   assign hold    = !st_empty && (pc_q == top_rpc);
   assign accept  = issue_i && !hold && !launch_i;
   assign st_push = (kind == BR_SPLIT) && !st_full;
   assign st_clr  = hold && !launch_i && (top_pm != '0);
   assign st_pop  = hold && !launch_i && (top_pm == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= PC_W'(RESET_PC);
         mask_q  <= '1;
         valid_q <= '1;
         ovf_q   <= 1'b0;
      end else if (launch_i) begin
         pc_q    <= launch_pc_i;
         mask_q  <= launch_mask;
         valid_q <= launch_mask;
         ovf_q   <= 1'b0;
      end else if (st_clr) begin
         pc_q   <= top_ppc;
         mask_q <= top_pm;
      end else if (st_pop) begin
         mask_q <= top_sm;
      end else if (accept) begin
         unique case (kind)
            BR_UNI_FALL: pc_q <= br_fall_i;
            BR_UNI_TAKE: pc_q <= br_target_i;
            BR_SPLIT: begin
               pc_q <= br_target_i;
               if (st_full) ovf_q  <= 1'b1;
               else         mask_q <= eff;
            end
            default: pc_q <= pc_q + PC_W'(PC_STEP);
         endcase
      end
   end

   assign pc_o       = pc_q;
   assign mask_o     = mask_q;
   assign hold_o     = hold;
   assign overflow_o = ovf_q;
   assign lane_en_o  = accept ? mask_q : '0;

   // R11: lanes beyond the launched count never become active
   p_dead_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~valid_q) == '0);
   // R4: a uniform branch leaves the stack depth unchanged
   p_uniform_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch_i && (kind == BR_UNI_FALL || kind == BR_UNI_TAKE)) |=> st_depth == $past(st_depth));
   // R5: a split narrows the mask to a strict subset
   p_split_narrows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_push |=> ((mask_q & ~$past(mask_q)) == '0) && (mask_q != $past(mask_q)));
   // R7: a pop keeps the pc at the reconvergence address
   p_pop_keeps_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_pop |=> pc_q == $past(pc_q));
   // R9: overflow only rises after a split met a full stack
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(st_full));
   // R9: overflow is sticky until a launch
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !launch_i) |=> ovf_q);
endmodule

// File: tb/sim_simt_mask_unit.sv
module sim_simt_mask_unit;
   localparam int D = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_i = 1'b0;
   logic [31:0] launch_pc_i = '0;
   logic [5:0]  launch_cnt_i = '0;
   logic        issue_i = 1'b0, br_i = 1'b0;
   logic [31:0] br_taken_i = '0, br_target_i = '0, br_fall_i = '0, br_reconv_i = '0;
   logic [31:0] pc_o, mask_o, lane_en_o;
   logic        hold_o, overflow_o;

   always #5 clk = ~clk;

   simt_mask_unit #(.LANES(32), .PC_W(32), .DEPTH(D), .PC_STEP(4)) u0 (
      .clk, .rst_n, .launch_i, .launch_pc_i, .launch_cnt_i, .issue_i, .br_i,
      .br_taken_i, .br_target_i, .br_fall_i, .br_reconv_i,
      .pc_o, .mask_o, .lane_en_o, .hold_o, .overflow_o);

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   // bench reference state
   logic [31:0] m_pc, m_mask;
   bit          m_ovf;
   int          m_sp;
   logic [31:0] m_rpc [D], m_ppc [D], m_pm [D], m_sm [D];

   function automatic logic [31:0] thermo(input int c);
      logic [63:0] t = (64'd1 << c) - 64'd1;
      return (c >= 32) ? 32'hffff_ffff : t[31:0];
   endfunction

   function automatic bit m_hold();
      return (m_sp > 0) && (m_pc == m_rpc[m_sp-1]);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input bit l, input logic [31:0] lpc, input int lc,
                      input bit is, input bit b, input logic [31:0] tk,
                      input logic [31:0] tg, input logic [31:0] fl, input logic [31:0] rc);
      logic [31:0] eff, en;
      bit h;
      launch_i = l; launch_pc_i = lpc; launch_cnt_i = 6'(lc);
      issue_i = is; br_i = b; br_taken_i = tk;
      br_target_i = tg; br_fall_i = fl; br_reconv_i = rc;
      #1;
      h  = m_hold();
      en = (is && !h && !l) ? m_mask : 32'h0;
      check(tag, "pc", pc_o, m_pc);
      check(tag, "mask", mask_o, m_mask);
      check(tag, "hold", 32'(hold_o), 32'(h));
      check(tag, "overflow", 32'(overflow_o), 32'(m_ovf));
      check(tag, "lane_en", lane_en_o, en);
      if (l) begin
         m_pc = lpc; m_mask = thermo(lc); m_sp = 0; m_ovf = 0;
      end else if (h) begin
         if (m_pm[m_sp-1] != 0) begin
            m_pc = m_ppc[m_sp-1]; m_mask = m_pm[m_sp-1]; m_pm[m_sp-1] = 0;
         end else begin
            m_mask = m_sm[m_sp-1]; m_sp--;
         end
      end else if (is) begin
         if (!b) m_pc = m_pc + 4;
         else begin
            eff = tk & m_mask;
            if (eff == 0) m_pc = fl;
            else if (eff == m_mask) m_pc = tg;
            else if (m_sp == D) begin m_ovf = 1; m_pc = tg; end
            else begin
               m_rpc[m_sp] = rc; m_ppc[m_sp] = fl;
               m_pm[m_sp] = m_mask & ~tk; m_sm[m_sp] = m_mask;
               m_sp++; m_pc = tg; m_mask = eff;
            end
         end
      end
      @(negedge clk);
   endtask

   task automatic step(input string tag);
      cyc(tag, 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask
   task automatic launch(input string tag, input logic [31:0] pc, input int c);
      cyc(tag, 1, pc, c, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic branch(input string tag, input logic [31:0] tk, input logic [31:0] tg,
                         input logic [31:0] fl, input logic [31:0] rc);
      cyc(tag, 0, 0, 0, 1, 1, tk, tg, fl, rc);
   endtask
   task automatic run_to_hold(input string tag);
      for (int k = 0; k < 64 && !hold_o; k++) step(tag);
   endtask

   initial begin
      m_pc = 0; m_mask = 32'hffff_ffff; m_ovf = 0; m_sp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1", "pc", pc_o, 32'h0);
      check("R1", "mask", mask_o, 32'hffff_ffff);
      check("R1", "overflow", 32'(overflow_o), 0);
      check("R1", "hold", 32'(hold_o), 0);
      @(negedge clk);

      // R2 / R3 / R10
      launch("R2", 32'h100, 32);
      check("R2", "pc", pc_o, 32'h100);
      step("R3");
      check("R3", "pc", pc_o, 32'h104);
      cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R10", "pc idle", pc_o, 32'h104);

      // R4 uniform branches
      branch("R4", 32'hffff_ffff, 32'h200, 32'h180, 32'h108);
      check("R4", "pc taken", pc_o, 32'h200);
      check("R4", "hold", 32'(hold_o), 0);
      branch("R4", 32'h0, 32'h300, 32'h280, 32'h204);
      check("R4", "pc fall", pc_o, 32'h280);

      // R11 one live thread
      launch("R11", 32'h0, 1);
      check("R11", "mask", mask_o, 32'h1);
      branch("R11", 32'hffff_fffe, 32'h40, 32'h80, 32'h8);
      check("R11", "pc fall", pc_o, 32'h80);
      branch("R11", 32'hffff_ffff, 32'h40, 32'h90, 32'h84);
      check("R11", "pc taken", pc_o, 32'h40);
      check("R11", "mask", mask_o, 32'h1);

      // R5 / R6 / R7 single split
      launch("R2", 32'h0, 32);
      branch("R5", 32'h0000_ffff, 32'h10, 32'h20, 32'h30);
      check("R5", "pc", pc_o, 32'h10);
      check("R5", "mask", mask_o, 32'h0000_ffff);
      run_to_hold("R5");
      check("R6", "hold", 32'(hold_o), 1);
      step("R6");
      check("R6", "pc", pc_o, 32'h20);
      check("R6", "mask", mask_o, 32'hffff_0000);
      run_to_hold("R6");
      step("R7");
      check("R7", "pc", pc_o, 32'h30);
      check("R7", "mask", mask_o, 32'hffff_ffff);
      check("R7", "hold", 32'(hold_o), 0);

      // R8 nested split
      launch("R2", 32'h0, 32);
      branch("R8", 32'h0000_ffff, 32'h4, 32'h40, 32'h80);
      branch("R8", 32'h0000_00ff, 32'h8, 32'h10, 32'h20);
      check("R8", "inner mask", mask_o, 32'h0000_00ff);
      run_to_hold("R8"); step("R8");
      check("R8", "inner fall mask", mask_o, 32'h0000_ff00);
      run_to_hold("R8"); step("R8");
      check("R8", "inner restore", mask_o, 32'h0000_ffff);
      run_to_hold("R8");
      check("R8", "outer pc", pc_o, 32'h80);
      step("R8");
      check("R8", "outer fall mask", mask_o, 32'hffff_0000);
      check("R8", "outer fall pc", pc_o, 32'h40);
      run_to_hold("R8"); step("R8");
      check("R8", "outer restore", mask_o, 32'hffff_ffff);

      // R9 overflow
      launch("R2", 32'h0, 32);
      branch("R9", 32'h0000_ffff, 32'h4, 32'h800, 32'h1000);
      branch("R9", 32'h0000_00ff, 32'h8, 32'h800, 32'h1000);
      branch("R9", 32'h0000_000f, 32'hc, 32'h800, 32'h1000);
      branch("R9", 32'h0000_0003, 32'h10, 32'h800, 32'h1000);
      check("R9", "no ovf yet", 32'(overflow_o), 0);
      branch("R9", 32'h0000_0001, 32'h14, 32'h800, 32'h1000);
      check("R9", "overflow", 32'(overflow_o), 1);
      check("R9", "pc", pc_o, 32'h14);
      check("R9", "mask kept", mask_o, 32'h0000_0003);
      step("R9");
      check("R9", "sticky", 32'(overflow_o), 1);
      launch("R2", 32'h40, 20);
      check("R2", "ovf cleared", 32'(overflow_o), 0);
      check("R2", "mask", mask_o, 32'h000f_ffff);

      // constrained random, compared each cycle with the model
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         bit l, is, b;
         int lc, sel;
         logic [31:0] tk;
         l   = ($urandom % 60) == 0;
         lc  = ($urandom % 20 == 0) ? 0 : 1 + ($urandom % 32);
         is  = ($urandom % 5) != 0;
         b   = ($urandom % 3) == 0;
         sel = $urandom % 4;
         tk  = (sel == 0) ? 32'hffff_ffff : (sel == 1) ? 32'h0 :
               (sel == 2) ? $urandom : (m_mask & $urandom);
         cyc("R8 random", l, 32'($urandom % 256) * 4, lc, is, b, tk,
             m_pc + 4, m_pc + 4 * (1 + $urandom % 3), m_pc + 4 * (4 + $urandom % 4));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule